// File: doc/BRIEF.md
# Calendar Time-of-Day Counter with Alarm

This block keeps a 32-bit packed time-and-date value and advances it once per pulse on a one-second tick input that an external prescaler supplies. When calendar mode is enabled, the fields carry seconds into minutes, minutes into hours, and hours into the day of the month. Days then carry into the month and months into a 6-bit year offset. Month lengths are applied per month, and years whose offset is divisible by four are treated as leap years. When calendar mode is off, the same register counts as a plain 32-bit binary counter.

Software loads the running value or an alarm value through a single-cycle write port. Both values are always visible on output ports. The alarm value is held in the same packed format as the running value. On a tick whose updated value equals the alarm, the block emits a one-cycle alarm pulse. With clear-on-alarm enabled, that match returns the value to its cleared state and also emits the overflow pulse.

Top module: `tod_calendar`

## Requirements
- R1: While reset is asserted, and after it is released, the running value, the alarm value, the alarm pulse and the overflow pulse are all zero until a write or a tick changes them.
- R2: With calendar mode off, each tick adds one to the running value, which appears on `value_o` one clock after the tick. Without a tick or a value write, the value holds.
- R3: With calendar mode off, a tick at 0xFFFFFFFF gives 0 and a one-cycle overflow pulse that is aligned with the new value.
- R4: In calendar mode the fields are, from bit 0: seconds [5:0], minutes [11:6], hours [16:12], day [21:17], month [25:22], year [31:26]. Seconds 59 and minutes 59 roll to 0 and carry, and hour 23 rolls to 0 and advances the day.
- R5: The day after the last day of a month is day 1 of the next month. The last day is 30 for months 4, 6, 9 and 11, and 31 for months 1, 3, 5, 7, 8, 10 and 12.
- R6: February (month 2) ends at day 29 when the year offset is divisible by 4, and at day 28 otherwise.
- R7: The day after month 12, day 31 is month 1, day 1, and the year offset increases by one.
- R8: Advancing past year 63, month 12, day 31, 23:59:59 gives year 0, month 1, day 1, 00:00:00 and a one-cycle overflow pulse.
- R9: A write with `wr_sel_i`=0 loads `wr_data_i` into the running value on the next clock. It takes priority over a tick in the same cycle and raises no alarm pulse. A write with `wr_sel_i`=1 loads the alarm value.
- R10: The alarm pulse is high for one cycle, aligned with the updated value, only when a tick produced a value equal to the alarm value. Equality without a tick gives no pulse.
- R11: With clear-on-alarm set, an alarm match loads the cleared value instead of the matched value and raises both the alarm pulse and the overflow pulse. The cleared value is 0 in binary mode, and month 1, day 1, all other fields zero in calendar mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-second advance enable, one clock wide |
| cal_en_i | input | 1 | 1 = calendar carry rules, 0 = binary count |
| clr_on_alarm_i | input | 1 | 1 = alarm match clears the value and raises overflow |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = running value, 1 = alarm value |
| wr_data_i | input | 32 | Write data |
| value_o | output | 32 | Running value |
| alarm_val_o | output | 32 | Alarm value |
| alarm_o | output | 1 | One-cycle alarm pulse |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
The rarest conditions are the month ends, leap Februaries and the final wrap of the year offset, which a free-running tick would take years of simulated seconds to reach. The bench therefore writes a value one tick before each boundary through the write port, and ticks once. It does this for every month over eight consecutive year offsets, which covers both leap and common years, and once more for the last second of year 63. Seconds carry is swept over every second value in the same way.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HOUR_W  = 5;
  localparam int DAY_W   = 5;
  localparam int MON_W   = 4;
  localparam int YEAR_W  = 6;
  localparam int VAL_W   = SEC_W + MIN_W + HOUR_W + DAY_W + MON_W + YEAR_W;

  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
  localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
  localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);
  localparam logic [MON_W-1:0]  MON_LAST  = MON_W'(12);
  localparam logic [YEAR_W-1:0] YEAR_LAST = {YEAR_W{1'b1}};

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
    logic [SEC_W-1:0]  sec;
  } tod_t;

  function automatic logic [VAL_W-1:0] cleared_value(input logic cal_mode);
    tod_t c;
    c = '0;
    if (cal_mode) begin
      c.day   = DAY_W'(1);
      c.month = MON_W'(1);
    end
    return c;
  endfunction
endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/tod_month_len.sv
module tod_month_len
  import tod_pkg::*;
(
  input  logic [MON_W-1:0]  month,
  input  logic [YEAR_W-1:0] year,
  output logic [DAY_W-1:0]  last_day
);
  logic leap;

  always_comb begin
    leap = (year[1:0] == 2'b00);
    unique case (month)
      MON_W'(2):                          last_day = leap ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6),
      MON_W'(9), MON_W'(11):              last_day = DAY_W'(30);
      default:                            last_day = DAY_W'(31);
    endcase
  end
endmodule

// File: rtl/tod_advance.sv
module tod_advance
  import tod_pkg::*;
(
  input  logic             cal_en,
  input  logic [VAL_W-1:0] cur,
  output logic [VAL_W-1:0] nxt,
  output logic             wrap
);
  tod_t            c;
  tod_t            n;
  logic [DAY_W-1:0] last_day;
  logic [VAL_W:0]   bin_sum;

  assign c = tod_t'(cur);

  tod_month_len u_mlen (
    .month    (c.month),
    .year     (c.year),
    .last_day (last_day)
  );

  always_comb begin
    bin_sum = {1'b0, cur} + {{VAL_W{1'b0}}, 1'b1};
    n       = c;
    wrap    = 1'b0;
    if (!cal_en) begin
      n    = tod_t'(bin_sum[VAL_W-1:0]);
      wrap = bin_sum[VAL_W];
    end else begin
      n.sec = c.sec + SEC_W'(1);
      if (c.sec >= SEC_LAST) begin
        n.sec    = '0;
        n.minute = c.minute + MIN_W'(1);
        if (c.minute >= MIN_LAST) begin
          n.minute = '0;
          n.hour   = c.hour + HOUR_W'(1);
          if (c.hour >= HOUR_LAST) begin
            n.hour = '0;
            n.day  = c.day + DAY_W'(1);
            if (c.day >= last_day) begin
              n.day   = DAY_W'(1);
              n.month = c.month + MON_W'(1);
              if (c.month >= MON_LAST) begin
                n.month = MON_W'(1);
                n.year  = c.year + YEAR_W'(1);
                wrap    = (c.year == YEAR_LAST);
              end
            end
          end
        end
      end
    end
  end

  assign nxt = n;
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cal_en_i,
  input  logic             clr_on_alarm_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [VAL_W-1:0] wr_data_i,
  output logic [VAL_W-1:0] value_o,
  output logic [VAL_W-1:0] alarm_val_o,
  output logic             alarm_o,
  output logic             ovf_o
);
  logic             rst_q_n;
  logic [VAL_W-1:0] val_q, val_d;
  logic [VAL_W-1:0] alm_q, alm_d;
  logic             alarm_q, alarm_d;
  logic             ovf_q, ovf_d;
  logic [VAL_W-1:0] adv_val;
  logic             adv_wrap;
  logic             hit;
  logic             wr_val, wr_alm;

  tod_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  tod_advance u_adv (
    .cal_en (cal_en_i),
    .cur    (val_q),
    .nxt    (adv_val),
    .wrap   (adv_wrap)
  );

  assign wr_val = wr_en_i && !wr_sel_i;
  assign wr_alm = wr_en_i &&  wr_sel_i;
  assign hit    = (adv_val == alm_q);

  always_comb begin
    val_d   = val_q;
    alm_d   = alm_q;
    alarm_d = 1'b0;
    ovf_d   = 1'b0;
    if (wr_alm) alm_d = wr_data_i;
    if (wr_val) begin
      val_d = wr_data_i;
    end else if (tick_i) begin
      val_d = adv_val;
      ovf_d = adv_wrap;
      if (hit) begin
        alarm_d = 1'b1;
        if (clr_on_alarm_i) begin
          val_d = cleared_value(cal_en_i);
          ovf_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      val_q   <= '0;
      alm_q   <= '0;
      alarm_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      val_q   <= val_d;
      alm_q   <= alm_d;
      alarm_q <= alarm_d;
      ovf_q   <= ovf_d;
    end
  end

  assign value_o     = val_q;
  assign alarm_val_o = alm_q;
  assign alarm_o     = alarm_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk
  import tod_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             cal_en_i,
  input logic             clr_on_alarm_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [VAL_W-1:0] wr_data_i,
  input logic [VAL_W-1:0] value_o,
  input logic [VAL_W-1:0] alarm_val_o,
  input logic             alarm_o,
  input logic             ovf_o
);
  // R2
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !(wr_en_i && !wr_sel_i)) |=> $stable(value_o));

  // R2
  bin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cal_en_i && !clr_on_alarm_i && !wr_en_i) |=> (value_o == $past(value_o) + 1'b1));

  // R9
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_sel_i) |=> (value_o == $past(wr_data_i)) && !alarm_o && !ovf_o);

  // R10
  alarm_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> $past(tick_i));

  // R10
  alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !$past(clr_on_alarm_i)) |-> (value_o == $past(alarm_val_o)));

  // R3
  ovf_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(tick_i));
endmodule

bind tod_calendar tod_calendar_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_q_n),
  .tick_i         (tick_i),
  .cal_en_i       (cal_en_i),
  .clr_on_alarm_i (clr_on_alarm_i),
  .wr_en_i        (wr_en_i),
  .wr_sel_i       (wr_sel_i),
  .wr_data_i      (wr_data_i),
  .value_o        (value_o),
  .alarm_val_o    (alarm_val_o),
  .alarm_o        (alarm_o),
  .ovf_o          (ovf_o)
);

// File: tb/tod_calendar_test.sv
module tod_calendar_test;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        cal_en_i;
  logic        clr_on_alarm_i;
  logic        wr_en_i;
  logic        wr_sel_i;
  logic [31:0] wr_data_i;
  logic [31:0] value_o;
  logic [31:0] alarm_val_o;
  logic        alarm_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;

  tod_calendar uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick_i),
    .cal_en_i       (cal_en_i),
    .clr_on_alarm_i (clr_on_alarm_i),
    .wr_en_i        (wr_en_i),
    .wr_sel_i       (wr_sel_i),
    .wr_data_i      (wr_data_i),
    .value_o        (value_o),
    .alarm_val_o    (alarm_val_o),
    .alarm_o        (alarm_o),
    .ovf_o          (ovf_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] pack(input int y, input int mo, input int d,
                                       input int h, input int mi, input int s);
    return {y[5:0], mo[3:0], d[4:0], h[4:0], mi[5:0], s[5:0]};
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic do_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_sel_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; cal_en_i = 1'b0; clr_on_alarm_i = 1'b0;
    wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", value_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", value_o, 32'd0);
    check("R1", alarm_val_o, 32'd0);
    check("R1", {30'd0, alarm_o, ovf_o}, 32'd0);

    // R2 binary counting
    for (int i = 1; i <= 3; i++) begin
      do_tick();
      check("R2", value_o, i);
    end
    repeat (3) @(negedge clk);
    check("R2", value_o, 32'd3);

    // R3 binary wrap
    do_write(1'b0, 32'hFFFF_FFFE);
    do_tick();
    check("R3", value_o, 32'hFFFF_FFFF);
    check("R3", {31'd0, ovf_o}, 32'd0);
    do_tick();
    check("R3", value_o, 32'd0);
    check("R3", {31'd0, ovf_o}, 32'd1);
    @(negedge clk);
    check("R3", {31'd0, ovf_o}, 32'd0);

    // R9 write beats tick
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'd100; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    check("R9", value_o, 32'd100);
    check("R9", {31'd0, alarm_o}, 32'd0);
    do_write(1'b1, 32'h1234_5678);
    check("R9", alarm_val_o, 32'h1234_5678);
    check("R9", value_o, 32'd100);

    // R4 seconds sweep and carries
    cal_en_i = 1'b1;
    for (int s = 0; s < 60; s++) begin
      do_write(1'b0, pack(5, 3, 10, 12, 34, s));
      do_tick();
      if (s < 59) check("R4", value_o, pack(5, 3, 10, 12, 34, s + 1));
      else        check("R4", value_o, pack(5, 3, 10, 12, 35, 0));
    end
    do_write(1'b0, pack(5, 3, 10, 12, 59, 59));
    do_tick();
    check("R4", value_o, pack(5, 3, 10, 13, 0, 0));
    do_write(1'b0, pack(5, 3, 10, 23, 59, 59));
    do_tick();
    check("R4", value_o, pack(5, 3, 11, 0, 0, 0));

    // R5 R6 R7 month ends over eight years
    for (int y = 0; y < 8; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int len;
        string tag;
        len = days_in(mo, y);
        tag = (mo == 2) ? "R6" : ((mo == 12) ? "R7" : "R5");
        do_write(1'b0, pack(y, mo, len - 1, 23, 59, 59));
        do_tick();
        check(tag, value_o, pack(y, mo, len, 0, 0, 0));
        do_write(1'b0, pack(y, mo, len, 23, 59, 59));
        do_tick();
        if (mo == 12) check(tag, value_o, pack(y + 1, 1, 1, 0, 0, 0));
        else          check(tag, value_o, pack(y, mo + 1, 1, 0, 0, 0));
      end
    end

    // R8 year wrap
    do_write(1'b0, pack(63, 12, 31, 23, 59, 59));
    do_tick();
    check("R8", value_o, pack(0, 1, 1, 0, 0, 0));
    check("R8", {31'd0, ovf_o}, 32'd1);

    // R10 alarm
    do_write(1'b1, pack(2, 4, 7, 8, 9, 10));
    do_write(1'b0, pack(2, 4, 7, 8, 9, 10));
    repeat (2) @(negedge clk);
    check("R10", {31'd0, alarm_o}, 32'd0);
    do_write(1'b0, pack(2, 4, 7, 8, 9, 9));
    do_tick();
    check("R10", value_o, pack(2, 4, 7, 8, 9, 10));
    check("R10", {31'd0, alarm_o}, 32'd1);
    check("R10", {31'd0, ovf_o}, 32'd0);
    do_tick();
    check("R10", {31'd0, alarm_o}, 32'd0);

    // R11 clear on alarm, calendar then binary
    clr_on_alarm_i = 1'b1;
    do_write(1'b0, pack(2, 4, 7, 8, 9, 9));
    do_tick();
    check("R11", value_o, pack(0, 1, 1, 0, 0, 0));
    check("R11", {30'd0, alarm_o, ovf_o}, 32'd3);
    cal_en_i = 1'b0;
    do_write(1'b1, 32'd50);
    do_write(1'b0, 32'd49);
    do_tick();
    check("R11", value_o, 32'd0);
    check("R11", {30'd0, alarm_o, ovf_o}, 32'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule